// File: doc/BRIEF.md
# Programmable Interval Timer with Pin Override

The block counts clock cycles against a 16-bit terminal count that software loads one byte at a time. A control write carries a command (start, stop or reset) together with the mode, the interrupt enable and the pin-routing choice.

In one-shot mode the timer produces a single timeout and then stops by itself. In re-triggerable mode it produces a continuous square wave with a period of N clocks. Each timeout latches a pending interrupt. Software clears it by reading the control register, or with a reset command.

While the timer runs, it accepts only the stop and reset commands, and every other register write is discarded. When routing is on, the timer waveform takes over general-purpose pin 0. The pin is then forced to output, and the pin's own level and direction settings have no effect until routing is turned off.

Top module: `interval_timer`

## Requirements
- R1: After reset the waveform output is HIGH, `irq` is 0, `rdData` is 0x00, the terminal count is 0 and routing is off, so the pin follows its own configuration inputs (input by default).
- R2: `wrAddr` 0 loads the count low byte and `wrAddr` 1 loads the high byte. `wrAddr` 2 is the control write, where bits [1:0] hold the command (00 none, 01 start, 10 stop, 11 reset), bit 2 selects the mode (0 one-shot, 1 re-triggerable), bit 3 enables the interrupt and bit 4 routes the waveform to the pin. The mode, enable and routing bits are taken only while the timer is idle.
- R3: In re-triggerable mode the output starts HIGH for ceil(N/2) clocks, then goes LOW for floor(N/2) clocks, and repeats with a period of N. A terminal count of 0 or 1 behaves as N = 2.
- R4: In one-shot mode the output stays HIGH for N-1 clocks after start and is LOW for exactly one clock. The timer then returns to idle with the output HIGH.
- R5: Whenever the timer is idle, the output is HIGH. A stop command makes the timer idle on the next clock.
- R6: While the timer runs, writes to either count byte are ignored. Control writes with command none or start are ignored entirely, including their mode, enable and routing bits.
- R7: The pending flag is set N clocks after start. In re-triggerable mode it is set again every N clocks, which is on each rising edge of the output.
- R8: `rdData` reads 0x01 only when the interrupt is enabled and an interrupt is pending, and 0x00 otherwise. `irq` is asserted under the same condition.
- R9: A control read (`ctlRd`) clears the pending flag. A stop command does not clear it, and neither does a later start.
- R10: A reset command, accepted even while the timer runs, stops the timer, clears the pending flag, and returns the count, mode, enable and routing to 0.
- R11: With routing on, `pinOe` is 1 and `pinDrive` equals the timer output, which is HIGH while idle. With routing off, `pinOe` follows `pinCfgOut` and `pinDrive` follows `pinCfgLevel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write target: 0 count low, 1 count high, 2 control |
| wrData | input | 8 | Write data |
| ctlRd | input | 1 | Control register read strobe (clears pending) |
| rdData | output | 8 | Control register read value |
| irq | output | 1 | Interrupt request (enabled and pending) |
| timerOut | output | 1 | Timer waveform |
| pinCfgOut | input | 1 | Normal direction setting of pin 0 (1 = output) |
| pinCfgLevel | input | 1 | Normal output level setting of pin 0 |
| pinOe | output | 1 | Pin 0 output enable |
| pinDrive | output | 1 | Pin 0 driven level |

## Verification
The properties checked on every cycle are the following:
- the output rests HIGH whenever the timer is idle;
- a stop command idles the timer on the next clock;
- a start issued while running leaves the configuration untouched;
- the read value tracks enable and pending;
- the pending flag holds through everything except a read or a reset;
- a reset command clears everything;
- the pin is overridden while routing is on.

The exact HIGH and LOW phase lengths for even and odd counts, the one-clock LOW pulse in one-shot mode, and the timing of each interrupt relative to start can only be shown by the bench. It does this by sweeping terminal counts and comparing the waveform against values computed arithmetically. The same holds for the fact that count-register writes made during a run do not change the period of the next run.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_START = 2'b01,
    CMD_STOP  = 2'b10,
    CMD_RESET = 2'b11
  } timerCmd_e;

  localparam logic [1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic startCnt;
    logic clearAll;
    logic run;
    logic periodic;
  } dpStrobe_t;

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16   // 9..16: low byte plus a partial or full high byte
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobe_t  strb,
  input  logic [7:0] wrData,
  output logic       termHit,
  output logic       waveOut
);

  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] termCnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nEff;
  logic [CNT_W:0]   sumHalf;
  logic [CNT_W-1:0] highLen;

  // Counts below 2 are clamped; the HIGH phase takes the odd clock.
  always_comb begin
    nEff    = (termCnt < CNT_W'(2)) ? CNT_W'(2) : termCnt;
    sumHalf = {1'b0, nEff} + (CNT_W+1)'(1);
    highLen = sumHalf[CNT_W:1];
    termHit = strb.run && (cnt == nEff - CNT_W'(1));
    if (!strb.run)
      waveOut = 1'b1;
    else if (strb.periodic)
      waveOut = (cnt < highLen);
    else
      waveOut = !termHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      termCnt <= '0;
      cnt     <= '0;
    end else if (strb.clearAll) begin
      termCnt <= '0;
      cnt     <= '0;
    end else begin
      if (strb.loadLo) termCnt[7:0]       <= wrData;
      if (strb.loadHi) termCnt[CNT_W-1:8] <= wrData[HI_W-1:0];
      if (strb.startCnt)
        cnt <= '0;
      else if (strb.run)
        cnt <= termHit ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [4:0] ctlBits,
  input  logic       ctlRd,
  input  logic       termHit,
  output dpStrobe_t  strb,
  output logic       runFlag,
  output logic       routeOn,
  output logic       irqEnFlag,
  output logic       pendFlag
);

  logic      modePer;
  logic      ctlWr;
  logic      idleCfg;
  logic      startCmd;
  logic      stopCmd;
  logic      resetCmd;
  timerCmd_e cmd;

  always_comb begin
    cmd      = timerCmd_e'(ctlBits[1:0]);
    ctlWr    = wrEn && (wrAddr == ADDR_CTRL);
    idleCfg  = ctlWr && !runFlag;
    startCmd = idleCfg && (cmd == CMD_START);
    stopCmd  = ctlWr && (cmd == CMD_STOP);
    resetCmd = ctlWr && (cmd == CMD_RESET);

    strb.loadLo   = wrEn && (wrAddr == ADDR_CNT_LO) && !runFlag;
    strb.loadHi   = wrEn && (wrAddr == ADDR_CNT_HI) && !runFlag;
    strb.startCnt = startCmd;
    strb.clearAll = resetCmd;
    strb.run      = runFlag;
    strb.periodic = modePer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runFlag   <= 1'b0;
      modePer   <= 1'b0;
      irqEnFlag <= 1'b0;
      routeOn   <= 1'b0;
      pendFlag  <= 1'b0;
    end else if (resetCmd) begin
      runFlag   <= 1'b0;
      modePer   <= 1'b0;
      irqEnFlag <= 1'b0;
      routeOn   <= 1'b0;
      pendFlag  <= 1'b0;
    end else begin
      if (idleCfg) begin
        modePer   <= ctlBits[2];
        irqEnFlag <= ctlBits[3];
        routeOn   <= ctlBits[4];
      end
      if (stopCmd)
        runFlag <= 1'b0;
      else if (startCmd)
        runFlag <= 1'b1;
      else if (termHit && !modePer)
        runFlag <= 1'b0;
      // A new timeout wins over a read in the same cycle.
      if (termHit)
        pendFlag <= 1'b1;
      else if (ctlRd)
        pendFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       ctlRd,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       timerOut,
  input  logic       pinCfgOut,
  input  logic       pinCfgLevel,
  output logic       pinOe,
  output logic       pinDrive
);

  dpStrobe_t strb;
  logic      termHit;
  logic      runFlag;
  logic      routeOn;
  logic      irqEnFlag;
  logic      pendFlag;

  timer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .ctlBits   (wrData[4:0]),
    .ctlRd     (ctlRd),
    .termHit   (termHit),
    .strb      (strb),
    .runFlag   (runFlag),
    .routeOn   (routeOn),
    .irqEnFlag (irqEnFlag),
    .pendFlag  (pendFlag)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (wrData),
    .termHit (termHit),
    .waveOut (timerOut)
  );

  always_comb begin
    irq      = irqEnFlag && pendFlag;
    rdData   = {7'd0, irq};
    pinOe    = routeOn ? 1'b1 : pinCfgOut;
    pinDrive = routeOn ? timerOut : pinCfgLevel;
  end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       ctlRd,
  input logic [7:0] rdData,
  input logic       timerOut,
  input logic       pinOe,
  input logic       pinDrive,
  input logic       runFlag,
  input logic       routeOn,
  input logic       irqEnFlag,
  input logic       pendFlag
);

  logic ctlWr;
  logic resetWr;
  logic stopWr;
  logic startWr;

  always_comb begin
    ctlWr   = wrEn && (wrAddr == 2'd2);
    resetWr = ctlWr && (wrData[1:0] == 2'b11);
    stopWr  = ctlWr && (wrData[1:0] == 2'b10);
    startWr = ctlWr && (wrData[1:0] == 2'b01);
  end

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !runFlag |-> timerOut);

  p_stop_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stopWr |=> !runFlag);

  p_start_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (runFlag && startWr) |=> ($stable(routeOn) && $stable(irqEnFlag)));

  p_read_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdData == ((irqEnFlag && pendFlag) ? 8'h01 : 8'h00));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlRd && !runFlag && !resetWr) |=> !pendFlag);

  p_pending_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pendFlag && !ctlRd && !resetWr) |=> pendFlag);

  p_reset_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resetWr |=> (!runFlag && !pendFlag && !routeOn && !irqEnFlag));

  p_pin_override_r11: assert property (@(posedge clk) disable iff (!rst_n)
    routeOn |-> (pinOe && (pinDrive == timerOut)));

endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .ctlRd     (ctlRd),
  .rdData    (rdData),
  .timerOut  (timerOut),
  .pinOe     (pinOe),
  .pinDrive  (pinDrive),
  .runFlag   (runFlag),
  .routeOn   (routeOn),
  .irqEnFlag (irqEnFlag),
  .pendFlag  (pendFlag)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       ctlRd = 1'b0;
  logic [7:0] rdData;
  logic       irq;
  logic       timerOut;
  logic       pinCfgOut = 1'b0;
  logic       pinCfgLevel = 1'b0;
  logic       pinOe;
  logic       pinDrive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  interval_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .ctlRd       (ctlRd),
    .rdData      (rdData),
    .irq         (irq),
    .timerOut    (timerOut),
    .pinCfgOut   (pinCfgOut),
    .pinCfgLevel (pinCfgLevel),
    .pinOe       (pinOe),
    .pinDrive    (pinDrive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCtl();
    @(negedge clk);
    ctlRd = 1'b1;
    @(negedge clk);
    ctlRd = 1'b0;
  endtask

  task automatic loadCount(input int n);
    wrReg(2'd0, 8'(n));
    wrReg(2'd1, 8'(n >> 8));
  endtask

  function automatic int effN(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  // Caller returns at the negedge right after the start edge (counter at 0).
  task automatic sweepRetrig(input int ne, input string req);
    for (int i = 0; i < 2 * ne; i++) begin
      if (i > 0) @(negedge clk);
      check(timerOut == ((i % ne) < (ne + 1) / 2), req, timerOut, int'((i % ne) < (ne + 1) / 2));
      check(irq == (i >= ne), "R7", irq, int'(i >= ne));
    end
  endtask

  task automatic sweepOneShot(input int ne);
    for (int i = 0; i <= ne + 1; i++) begin
      if (i > 0) @(negedge clk);
      check(timerOut == (i != ne - 1), "R4", timerOut, int'(i != ne - 1));
      check(irq == (i >= ne), "R7", irq, int'(i >= ne));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(timerOut == 1'b1, "R1", timerOut, 1);
    check(irq == 1'b0, "R1", irq, 0);
    check(rdData == 8'h00, "R1", rdData, 0);
    check(pinOe == 1'b0, "R1", pinOe, 0);

    // R3, R7: re-triggerable sweep over small counts, including 0 and 1 (R2 encoding 0x0D)
    for (int n = 0; n <= 9; n++) begin
      readCtl();
      loadCount(n);
      wrReg(2'd2, 8'h0D);
      sweepRetrig(effN(n), "R3");
      wrReg(2'd2, 8'h02);
      check(timerOut == 1'b1, "R5", timerOut, 1);
      // R9: stop keeps pending, read clears it
      check(rdData == 8'h01, "R9", rdData, 1);
      readCtl();
      check(rdData == 8'h00, "R9", rdData, 0);
    end

    // R2 high byte: N = 0x0103 = 259
    loadCount(259);
    wrReg(2'd2, 8'h0D);
    sweepRetrig(259, "R2");
    wrReg(2'd2, 8'h02);
    readCtl();

    // R4 one-shot sweep (control 0x09)
    for (int n = 0; n <= 7; n++) begin
      readCtl();
      loadCount(n);
      wrReg(2'd2, 8'h09);
      sweepOneShot(effN(n));
      check(rdData == 8'h01, "R8", rdData, 1);
    end

    // R9: restart after stop does not clear pending (pending from last one-shot)
    loadCount(20);
    wrReg(2'd2, 8'h0D);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R9", irq, 1);
    wrReg(2'd2, 8'h02);
    wrReg(2'd2, 8'h0D);
    check(irq == 1'b1, "R9", irq, 1);
    wrReg(2'd2, 8'h02);
    readCtl();

    // R8: pending with interrupt disabled reads 0, enabling later reads 1
    loadCount(3);
    wrReg(2'd2, 8'h01);
    repeat (4) @(negedge clk);
    check(rdData == 8'h00, "R8", rdData, 0);
    check(irq == 1'b0, "R8", irq, 0);
    wrReg(2'd2, 8'h08);
    check(rdData == 8'h01, "R8", rdData, 1);
    readCtl();
    check(rdData == 8'h00, "R9", rdData, 0);

    // R6: writes while running are ignored
    pinCfgOut = 1'b0;
    loadCount(6);
    wrReg(2'd2, 8'h0D);
    wrReg(2'd0, 8'd2);
    wrReg(2'd2, 8'h11);
    check(pinOe == 1'b0, "R6", pinOe, 0);
    wrReg(2'd2, 8'h02);
    readCtl();
    wrReg(2'd2, 8'h0D);
    sweepRetrig(6, "R6");

    // R10: reset while running
    wrReg(2'd2, 8'h03);
    check(timerOut == 1'b1, "R10", timerOut, 1);
    check(irq == 1'b0, "R10", irq, 0);
    check(rdData == 8'h00, "R10", rdData, 0);
    wrReg(2'd2, 8'h09);            // count now 0, one-shot: behaves as N = 2
    sweepOneShot(2);
    readCtl();

    // R11: pin routing
    pinCfgOut = 1'b0; pinCfgLevel = 1'b0;
    wrReg(2'd2, 8'h10);
    check(pinOe == 1'b1, "R11", pinOe, 1);
    check(pinDrive == 1'b1, "R11", pinDrive, 1);
    loadCount(4);
    wrReg(2'd2, 8'h15);
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      check(pinDrive == ((i % 4) < 2), "R11", pinDrive, int'((i % 4) < 2));
    end
    wrReg(2'd2, 8'h02);
    wrReg(2'd2, 8'h00);
    for (int v = 0; v < 4; v++) begin
      pinCfgOut = v[0]; pinCfgLevel = v[1];
      #1;
      check(pinOe == v[0], "R11", pinOe, v[0]);
      check(pinDrive == v[1], "R11", pinDrive, v[1]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule